// File: doc/BRIEF.md
# Receive Descriptor Engine

This block receives frames from a byte stream and places each accepted frame into system memory. It takes its buffers from a ring of receive descriptors held in a descriptor RAM outside the block. Each descriptor is a pair of words: a status word at an even index and a buffer pointer at the next index. The receive ring starts at a configurable base index, which is the boundary where the transmit descriptors end. When the engine reaches the end of the ring, it returns to that base index and not to index 0.

A frame is first collected in an internal byte buffer until its end-of-frame marker arrives. The engine then decides from the buffered frame whether to keep it. A frame shorter than a header is discarded. A frame whose destination address does not match the station address is dropped, unless promiscuous mode is on. An accepted frame is written out as big-endian 32-bit words, one word per cycle. The engine then writes the frame length and the length error flags back into the descriptor, clears the descriptor's ready bit, and moves to the next descriptor.

The engine has two interrupt sources. The done source is set when a frame completes. The busy source is set when a frame arrives while no ready descriptor is available. Each source has a mask, and each is cleared by writing a one to it.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset, `int_src` is 0, `irq` is 0, there is no descriptor write and no memory write, and `dsc_rd_idx` equals `cfg_ring_base`.
- R2: While `cfg_rx_en` has been low since reset, frames on the stream cause no descriptor write and no memory write.
- R3: If a frame starts while the engine waits on a descriptor whose ready bit (status bit 15) is 0 and `cfg_rx_en` is high, then busy source `int_src[1]` is set and the frame is lost.
- R4: A frame of fewer than 14 bytes is discarded. Its descriptor is left unchanged and the ring index does not move.
- R5: With `cfg_promisc` low, a frame is accepted only if frame bytes 0..5 equal `cfg_mac` bytes 5..0, where byte k is `cfg_mac[8k+7:8k]`. A frame that fails this check is dropped and its descriptor is left unchanged. With `cfg_promisc` high, the address is not checked.
- R6: Word k of an accepted frame is written to the buffer pointer plus 4k. Frame byte 4k goes to bits 31:24 of the word. Exactly ceil(len/4) words are written, and bytes past the frame length read as 0.
- R7: On completion, the descriptor status word receives the stored length in bits 31:16 and has bit 15 (ready) cleared. Bits 14:7 keep their previous value. Done source `int_src[0]` is set.
- R8: Accepting a descriptor clears status bits 6:0. At writeback, bit 0 (too short) is set when the length is below `cfg_min_len`, and bit 1 (too big) is set when the length is above `cfg_max_len`.
- R9: A frame longer than the buffer (BUF_BYTES) is cut to BUF_BYTES bytes, and its too-big bit is set.
- R10: After writeback, the ring index becomes `cfg_ring_base` if status bit 13 (wrap) was set or the index was at least DESC_LIMIT. Otherwise the index advances by 2.
- R11: `irq` is high while any source bit of `int_src` is set together with its bit in `int_mask`. A 1 on `int_clr` clears the matching source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept every destination address |
| cfg_mac | input | 48 | Station address, byte k at bits 8k+7:8k |
| cfg_min_len | input | 16 | Minimum frame length for the too-short flag |
| cfg_max_len | input | 16 | Maximum frame length for the too-big flag |
| cfg_ring_base | input | IDX_W | First receive descriptor index |
| int_mask | input | 2 | Interrupt masks: bit 0 done, bit 1 busy |
| int_clr | input | 2 | Write-one-to-clear for the source bits |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the last byte of a frame |
| dsc_rd_idx | output | IDX_W | Current descriptor index |
| dsc_stat_i | input | 32 | Descriptor RAM word at `dsc_rd_idx` (combinational read) |
| dsc_buf_i | input | 32 | Descriptor RAM word at `dsc_rd_idx`+1 |
| dsc_wr_en | output | 1 | Descriptor status writeback strobe |
| dsc_wr_idx | output | IDX_W | Writeback index |
| dsc_wr_data | output | 32 | Writeback status word |
| mem_wr_en | output | 1 | Memory word write strobe |
| mem_wr_addr | output | 32 | Memory byte address |
| mem_wr_data | output | 32 | Memory word data |
| int_src | output | 2 | Source bits: bit 0 done, bit 1 busy |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs. First, the descriptor RAM is stable between the cycle the engine reads a descriptor and the cycle a busy event is flagged. Second, the buffer pointer plus the frame length does not wrap around the 32-bit address space, so consecutive word writes of one frame rise by exactly 4. The bench rewrites a descriptor only while the engine is idle on its side of the ring, and it keeps a single pointer low in memory. It sends frames only with gaps between them and never starts a frame while arming a descriptor, so a frame is never lost through that race.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_BD,
        ST_RECV,
        ST_WRITE
    } rx_state_t;

    // Descriptor status word, MSB first
    typedef struct packed {
        logic [15:0] len;
        logic        ready;
        logic        spare;
        logic        wrap;
        logic [5:0]  keep;
        logic [6:0]  flags;
    } dsc_word_t;

    localparam int HDR_BYTES  = 14;
    localparam int MAC_BYTES  = 6;
    localparam int WORD_BYTES = 4;
    localparam int SRC_DONE   = 0;
    localparam int SRC_BUSY   = 1;
    localparam int FL_SHORT   = 0;
    localparam int FL_BIG     = 1;

    function automatic logic [6:0] len_flags(
        input logic [15:0] len,
        input logic [15:0] min_len,
        input logic [15:0] max_len,
        input logic        trunc
    );
        logic [6:0] f;
        f = '0;
        f[FL_SHORT] = (len < min_len);
        f[FL_BIG]   = trunc || (len > max_len);
        return f;
    endfunction

    function automatic dsc_word_t close_desc(
        input dsc_word_t   base,
        input logic [15:0] len,
        input logic [6:0]  flags
    );
        dsc_word_t w;
        w       = base;
        w.len   = len;
        w.ready = 1'b0;
        w.flags = flags;
        return w;
    endfunction

endpackage

// File: rtl/rxd_frame_buf.sv
module rxd_frame_buf
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int LEN_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    input  logic [LEN_W-1:0] off_i,
    input  logic [47:0]      mac_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] cnt_next_o,
    output logic             trunc_o,
    output logic             trunc_next_o,
    output logic [31:0]      word_o,
    output logic             da_ok_o
);
    localparam int AW = $clog2(BUF_BYTES);

    logic [7:0]       mem_q [BUF_BYTES];
    logic [LEN_W-1:0] cnt_q;
    logic             trunc_q;
    logic             room;

    assign room = cnt_q < LEN_W'(BUF_BYTES);

    always_ff @(posedge clk) begin
        if (start_i)
            mem_q[0] <= byte_i;
        else if (take_i && room)
            mem_q[cnt_q[AW-1:0]] <= byte_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            trunc_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_next_o;
            trunc_q <= trunc_next_o;
        end
    end

    always_comb begin
        cnt_next_o   = cnt_q;
        trunc_next_o = trunc_q;
        if (start_i) begin
            cnt_next_o   = LEN_W'(1);
            trunc_next_o = 1'b0;
        end else if (take_i) begin
            if (room) cnt_next_o = cnt_q + LEN_W'(1);
            else      trunc_next_o = 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign trunc_o = trunc_q;

    // big-endian word assembly, bytes past the frame length read as zero
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        logic [LEN_W:0] pos;
        assign pos = {1'b0, off_i} + (LEN_W+1)'(k);
        assign word_o[8*(WORD_BYTES-1-k) +: 8] =
            (pos < {1'b0, cnt_q}) ? mem_q[pos[AW-1:0]] : 8'h00;
    end

    // frame byte i is compared with station byte 5-i
    always_comb begin
        da_ok_o = 1'b1;
        for (int i = 0; i < MAC_BYTES; i++) begin
            if (mem_q[AW'(i)] != mac_i[8*(MAC_BYTES-1-i) +: 8])
                da_ok_o = 1'b0;
        end
    end

endmodule

// File: rtl/rxd_ring_idx.sv
module rxd_ring_idx #(
    parameter int IDX_W      = 4,
    parameter int DESC_LIMIT = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] base_i,
    input  logic             step_i,
    input  logic             wrap_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_q;
    logic             at_end;

    assign at_end = wrap_i || (idx_q >= IDX_W'(DESC_LIMIT));

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= base_i;
        else if (step_i)
            idx_q <= at_end ? base_i : idx_q + IDX_W'(2);
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/rxd_irq.sv
module rxd_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] src_o,
    output logic            irq_o
);
    logic [NSRC-1:0] src_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)           src_q[s] <= 1'b0;
            else if (set_i[s]) src_q[s] <= 1'b1;
            else if (clr_i[s]) src_q[s] <= 1'b0;
        end
    end

    assign src_o = src_q;
    assign irq_o = |(src_q & mask_i);

endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES  = 64,
    parameter int IDX_W      = 4,
    parameter int DESC_LIMIT = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rx_en,
    input  logic             cfg_promisc,
    input  logic [47:0]      cfg_mac,
    input  logic [15:0]      cfg_min_len,
    input  logic [15:0]      cfg_max_len,
    input  logic [IDX_W-1:0] cfg_ring_base,
    input  logic [1:0]       int_mask,
    input  logic [1:0]       int_clr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic [IDX_W-1:0] dsc_rd_idx,
    input  logic [31:0]      dsc_stat_i,
    input  logic [31:0]      dsc_buf_i,
    output logic             dsc_wr_en,
    output logic [IDX_W-1:0] dsc_wr_idx,
    output logic [31:0]      dsc_wr_data,
    output logic             mem_wr_en,
    output logic [31:0]      mem_wr_addr,
    output logic [31:0]      mem_wr_data,
    output logic [1:0]       int_src,
    output logic             irq
);
    localparam int LEN_W = $clog2(BUF_BYTES + 1);

    rx_state_t        state_q, state_d;
    logic             mid_q, cap_q;
    dsc_word_t        base_q, rd_w, wb_w;
    logic [31:0]      ptr_q;
    logic [LEN_W-1:0] off_q;

    logic             frame_start, cap_start, cap_take, eof;
    logic [LEN_W-1:0] cnt, cnt_next;
    logic             trunc, trunc_next, da_ok;
    logic             len_ok, accept, last_word, busy_evt;
    logic [LEN_W:0]   off_next4;
    logic [15:0]      len16;
    logic [IDX_W-1:0] idx;

    assign rd_w        = dsc_word_t'(dsc_stat_i);
    assign frame_start = in_valid && !mid_q;
    assign cap_start   = (state_q == ST_RECV) && frame_start;
    assign cap_take    = cap_q && in_valid;
    assign eof         = in_valid && in_last && (cap_start || cap_q);
    assign len_ok      = cnt_next >= LEN_W'(HDR_BYTES);
    assign accept      = len_ok && (cfg_promisc || da_ok);
    assign off_next4   = {1'b0, off_q} + (LEN_W+1)'(WORD_BYTES);
    assign last_word   = off_next4 >= {1'b0, cnt};
    assign busy_evt    = (state_q == ST_WAIT_BD) && cfg_rx_en && !rd_w.ready && frame_start;
    assign len16       = 16'(cnt);

    rxd_frame_buf #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_buf (
        .clk          (clk),
        .rst          (rst),
        .start_i      (cap_start),
        .take_i       (cap_take),
        .byte_i       (in_data),
        .off_i        (off_q),
        .mac_i        (cfg_mac),
        .cnt_o        (cnt),
        .cnt_next_o   (cnt_next),
        .trunc_o      (trunc),
        .trunc_next_o (trunc_next),
        .word_o       (mem_wr_data),
        .da_ok_o      (da_ok)
    );

    rxd_ring_idx #(.IDX_W(IDX_W), .DESC_LIMIT(DESC_LIMIT)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .base_i (cfg_ring_base),
        .step_i (dsc_wr_en),
        .wrap_i (base_q.wrap),
        .idx_o  (idx)
    );

    rxd_irq #(.NSRC(2)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_i  ({busy_evt, dsc_wr_en}),
        .clr_i  (int_clr),
        .mask_i (int_mask),
        .src_o  (int_src),
        .irq_o  (irq)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cfg_rx_en) state_d = ST_WAIT_BD;
            ST_WAIT_BD: begin
                if (rd_w.ready)     state_d = ST_RECV;
                else if (!cfg_rx_en) state_d = ST_IDLE;
            end
            ST_RECV: begin
                if (eof) begin
                    if (!len_ok)     state_d = ST_IDLE;
                    else if (accept) state_d = ST_WRITE;
                end
            end
            ST_WRITE:   if (last_word) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mid_q   <= 1'b0;
            cap_q   <= 1'b0;
            base_q  <= '0;
            ptr_q   <= '0;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) mid_q <= !in_last;
            if (cap_start && !in_last) cap_q <= 1'b1;
            else if (eof)              cap_q <= 1'b0;
            if (state_q == ST_WAIT_BD && rd_w.ready) begin
                base_q       <= rd_w;
                base_q.flags <= '0;
                ptr_q        <= dsc_buf_i;
            end
            if (state_q == ST_RECV)       off_q <= '0;
            else if (state_q == ST_WRITE) off_q <= off_q + LEN_W'(WORD_BYTES);
        end
    end

    assign wb_w        = close_desc(base_q, len16,
                                    len_flags(len16, cfg_min_len, cfg_max_len, trunc));
    assign dsc_rd_idx  = idx;
    assign dsc_wr_idx  = idx;
    assign dsc_wr_en   = (state_q == ST_WRITE) && last_word;
    assign dsc_wr_data = wb_w;
    assign mem_wr_en   = (state_q == ST_WRITE);
    assign mem_wr_addr = ptr_q + 32'(off_q);

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
    parameter int BUF_BYTES = 64
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] dsc_stat_i,
    input logic        dsc_wr_en,
    input logic [31:0] dsc_wr_data,
    input logic        mem_wr_en,
    input logic [31:0] mem_wr_addr,
    input logic [1:0]  int_src
);
    assert_ready_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> !dsc_wr_data[15]);

    assert_done_src_R7: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |=> int_src[0]);

    assert_busy_noready_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(int_src[1]) |-> $past(!dsc_stat_i[15]));

    assert_len_bounds_R4: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> (dsc_wr_data[31:16] >= 16'd14) &&
                      (dsc_wr_data[31:16] <= 16'(BUF_BYTES)));

    assert_wb_with_last_word_R6: assert property (@(posedge clk) disable iff (rst)
        dsc_wr_en |-> mem_wr_en);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && $past(mem_wr_en)) |-> mem_wr_addr == $past(mem_wr_addr) + 32'd4);

endmodule

bind rx_desc_engine rxd_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dsc_stat_i  (dsc_stat_i),
    .dsc_wr_en   (dsc_wr_en),
    .dsc_wr_data (dsc_wr_data),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .int_src     (int_src)
);

// File: tb/rx_desc_engine_tb.sv
module rx_desc_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUF   = 64;
    localparam int IDXW  = 4;
    localparam int LIMIT = 14;
    localparam logic [IDXW-1:0] BASE = 4'd8;
    localparam logic [47:0] MAC = 48'h0A1B2C3D4E5F;
    localparam logic [31:0] PTR = 32'h80;

    logic clk = 0, rst = 1;
    logic cfg_rx_en = 0, cfg_promisc = 0;
    logic [15:0] cfg_min_len = 16'd20, cfg_max_len = 16'd60;
    logic [1:0] int_mask = 2'b11, int_clr = 2'b00;
    logic in_valid = 0, in_last = 0;
    logic [7:0] in_data = 0;
    logic [IDXW-1:0] dsc_rd_idx, dsc_wr_idx;
    logic [31:0] dsc_stat_i, dsc_buf_i, dsc_wr_data, mem_wr_addr, mem_wr_data;
    logic dsc_wr_en, mem_wr_en, irq;
    logic [1:0] int_src;

    logic [31:0] dram [16];
    logic [31:0] mem [128];
    int wb_cnt = 0, mw_cnt = 0;
    int checks = 0, errors = 0;
    logic [IDXW-1:0] exp_idx;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_desc_engine #(.BUF_BYTES(BUF), .IDX_W(IDXW), .DESC_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_promisc(cfg_promisc),
        .cfg_mac(MAC), .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
        .cfg_ring_base(BASE), .int_mask(int_mask), .int_clr(int_clr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .dsc_rd_idx(dsc_rd_idx), .dsc_stat_i(dsc_stat_i), .dsc_buf_i(dsc_buf_i),
        .dsc_wr_en(dsc_wr_en), .dsc_wr_idx(dsc_wr_idx), .dsc_wr_data(dsc_wr_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .int_src(int_src), .irq(irq)
    );

    assign dsc_stat_i = dram[dsc_rd_idx];
    assign dsc_buf_i  = dram[dsc_rd_idx + 4'd1];

    always @(posedge clk) begin
        if (dsc_wr_en) begin
            dram[dsc_wr_idx] <= dsc_wr_data;
            wb_cnt <= wb_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_wr_addr[8:2]] <= mem_wr_data;
            mw_cnt <= mw_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int pos, input int seed, input bit match);
        logic [7:0] b;
        if (pos < 6) begin
            b = MAC[8*(5-pos) +: 8];
            if (!match && pos == 2) b = b ^ 8'h10;
        end else
            b = 8'(seed + pos * 13);
        return b;
    endfunction

    function automatic logic [31:0] armed_word(input bit wrap);
        return {16'h0, 1'b1, 1'b0, wrap, 6'b101010, 7'h7f};
    endfunction

    task automatic arm(input bit wrap);
        dram[exp_idx]        = armed_word(wrap);
        dram[exp_idx + 4'd1] = PTR;
        for (int i = 32; i < 54; i++) mem[i] = 32'hDEADBEEF;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input int n, input int seed, input bit match);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1;
            in_data  = fbyte(i, seed, match);
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 0;
        in_last  = 0;
    endtask

    task automatic rx_good(input int n, input int seed, input bit match, input bit wrap);
        int old, t, s, nw;
        logic [31:0] exp_w, ew;
        bit big, sht;
        arm(wrap);
        old = wb_cnt;
        send(n, seed, match);
        t = 0;
        while (wb_cnt == old && t < 400) begin @(negedge clk); t++; end
        chk(wb_cnt != old, "R7", "writeback seen", 32'(wb_cnt), 32'(old + 1));
        s   = (n > BUF) ? BUF : n;
        sht = s < int'(cfg_min_len);
        big = (n > BUF) || (s > int'(cfg_max_len));
        exp_w = {16'(s), 1'b0, 1'b0, wrap, 6'b101010, 5'b0, big, sht};
        chk(dram[exp_idx] == exp_w, "R7 R8 R9", "status word", dram[exp_idx], exp_w);
        nw = (s + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            for (int b = 0; b < 4; b++)
                ew[8*(3-b) +: 8] = (4*k + b < s) ? fbyte(4*k + b, seed, match) : 8'h00;
            chk(mem[32 + k] == ew, "R6", "data word", mem[32 + k], ew);
        end
        chk(mem[32 + nw] == 32'hDEADBEEF, "R6", "word past end", mem[32 + nw], 32'hDEADBEEF);
        chk(int_src[0] == 1'b1, "R7", "done source", 32'(int_src), 32'd1);
        chk(irq == int_mask[0], "R11", "irq level", 32'(irq), 32'(int_mask[0]));
        exp_idx = (wrap || exp_idx >= 4'(LIMIT)) ? BASE : exp_idx + 4'd2;
        chk(dsc_rd_idx == exp_idx, "R10", "ring index", 32'(dsc_rd_idx), 32'(exp_idx));
        int_clr = 2'b01;
        @(negedge clk);
        int_clr = 2'b00;
        chk(int_src[0] == 1'b0, "R11", "done cleared", 32'(int_src), 32'd0);
    endtask

    task automatic rx_drop(input int n, input bit match, input string req);
        int oldw, oldm;
        arm(1'b0);
        oldw = wb_cnt; oldm = mw_cnt;
        send(n, 5, match);
        repeat (30) @(negedge clk);
        chk(dram[exp_idx] == armed_word(1'b0), req, "descriptor untouched",
            dram[exp_idx], armed_word(1'b0));
        chk(wb_cnt == oldw && mw_cnt == oldm, req, "no writes",
            32'(mw_cnt - oldm), 32'd0);
        chk(dsc_rd_idx == exp_idx, req, "index kept", 32'(dsc_rd_idx), 32'(exp_idx));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dram[i] = '0;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        exp_idx = BASE;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(int_src == 2'b00 && irq == 1'b0, "R1", "irq state", {30'b0, int_src}, 32'd0);
        chk(!dsc_wr_en && !mem_wr_en, "R1", "no writes", {30'b0, dsc_wr_en, mem_wr_en}, 32'd0);
        chk(dsc_rd_idx == BASE, "R1", "ring start", 32'(dsc_rd_idx), 32'(BASE));

        // disabled: frame must leave no trace (R2)
        arm(1'b0);
        send(20, 3, 1'b1);
        repeat (20) @(negedge clk);
        chk(wb_cnt == 0 && mw_cnt == 0, "R2", "disabled writes", 32'(mw_cnt), 32'd0);
        cfg_rx_en = 1;

        // length sweep, wrap bit on every fifth frame (R6 R7 R8 R9 R10)
        for (int n = 14; n <= 70; n++) rx_good(n, n * 3, 1'b1, (n % 5) == 0);

        // short frames (R4)
        rx_drop(13, 1'b1, "R4");
        rx_drop(1, 1'b1, "R4");
        rx_good(16, 9, 1'b1, 1'b0);

        // address filter (R5)
        rx_drop(30, 1'b0, "R5");
        cfg_promisc = 1;
        rx_good(30, 11, 1'b0, 1'b0);
        cfg_promisc = 0;
        rx_good(31, 12, 1'b1, 1'b0);

        // busy: no ready descriptor (R3)
        dram[exp_idx] = 32'h0;
        repeat (4) @(negedge clk);
        send(20, 4, 1'b1);
        @(negedge clk);
        chk(int_src[1] == 1'b1, "R3", "busy source", 32'(int_src), 32'd2);
        chk(irq == 1'b1, "R11", "busy irq", 32'(irq), 32'd1);
        chk(mw_cnt == mw_cnt && dram[exp_idx] == 32'h0, "R3", "frame lost", dram[exp_idx], 32'h0);
        int_clr = 2'b10;
        @(negedge clk);
        int_clr = 2'b00;
        chk(int_src == 2'b00 && irq == 1'b0, "R11", "busy cleared", 32'(int_src), 32'd0);

        // masked interrupts (R11)
        int_mask = 2'b00;
        rx_good(40, 21, 1'b1, 1'b0);
        int_mask = 2'b11;
        cfg_min_len = 16'd40; cfg_max_len = 16'd45;
        rx_good(39, 22, 1'b1, 1'b0);
        rx_good(46, 23, 1'b1, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule